// File: doc/BRIEF.md
# PWM Duty-Cycle Extractor

This block turns an external pulse-width-modulated brightness pin into an 8-bit duty code with 256 levels. It runs on a fast system clock that is unrelated to the pin. Inside it, the pin passes through a synchroniser. The block then counts the clock cycles from one rising edge to the next, which gives the period, and from a rising edge to the following falling edge, which gives the high time. After each closed period, a sequential divider works out `high * 256 / period`. Pin frequencies from 200 Hz to 10 kHz are handled by one set of counters, because the code depends only on the ratio.

The code feeds either the dimming duty or a 256-step DC current level, so it must not flicker when the input jitters by half a step. A newly computed value therefore replaces the held code only when two consecutive periods both disagree with it. When the pin stops toggling, the block raises a no-edge flag after a timeout that is longer than the slowest legal period. It then forces the code to full scale if the pin is stuck high, or to zero if it is stuck low. Until the first measurement is adopted, the code sits at full scale, so a brightness scaler starts at 100 %.

Top module: `pwm_duty_extract`

## Requirements
- R1: After reset, before any measurement is adopted, `duty_code` is 255, `duty_valid` is 0 and `no_edge` is 0.
- R2: For a pin that stays high H cycles and low L cycles per period, with P = H + L and H ≤ TIMEOUT, each measurement computes min(255, floor(H·256/P)). An adopted code equals that value.
- R3: `duty_valid` is a single-cycle pulse, given once for each period that is closed by a rising edge while the block is armed. It comes in the same cycle as any code update caused by that measurement.
- R4: A computed value that differs from the held code in only one period is ignored. A value is adopted (the newer one) when two consecutive measurements both differ from the held code. Jitter that alternates the computed value between two neighbours therefore does not make the code toggle.
- R5: If no edge occurs for more than TIMEOUT cycles, `no_edge` goes to 1 and the code becomes 255 if the pin stayed high, or 0 if it stayed low. The next edge clears `no_edge`.
- R6: After a timeout, the first rising edge only re-arms the measurement and produces no `duty_valid`. The hysteresis state is cleared, so two further measured periods are needed to adopt a new code.
- R7: Extreme duties resolve without overflow: one high cycle in a 400-cycle period gives 0, and one low cycle in a 400-cycle period gives 255.
- R8: When a rising edge arrives in the very cycle the timeout expires (low time of exactly TIMEOUT+1 cycles), `no_edge` is high for exactly one cycle, the code is forced to 0, and that rising edge only arms the next period. A low time of TIMEOUT cycles causes no timeout and is measured normally.
- R9: While `en` is 0, the code returns to 255 on the next cycle, `duty_valid` stays 0, `no_edge` stays 0 and any measurement in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Asynchronous PWM brightness pin |
| en | input | 1 | Measurement enable; low clears state |
| duty_code | output | 8 | Held duty code, 0..255 |
| duty_valid | output | 1 | One-cycle pulse per measured period |
| no_edge | output | 1 | High while the pin has been idle longer than TIMEOUT |

## Verification
The timeout expiry and a rising edge can land in the same cycle. If they do, the block has to decide at once whether that edge closes a measurable period or only re-arms after the idle span. The bench provokes this by holding the pin low for exactly TIMEOUT+1 cycles before a rising edge. It then judges that `no_edge` pulsed for one cycle, that the code was forced to 0, and that only the periods after that edge produced valid strobes. A companion run uses a low time one cycle shorter and expects an ordinary measurement with no flag.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  typedef logic [7:0] code_t;
  localparam code_t CODE_FULL = 8'hFF;
  localparam code_t CODE_ZERO = 8'h00;
  localparam int QBITS = 9;

  // clamp a 9-bit quotient to the 8-bit code range
  function automatic code_t sat_code(input logic [QBITS-1:0] q);
    return (q > 9'd255) ? CODE_FULL : q[7:0];
  endfunction

  // code imposed when the pin has stopped toggling
  function automatic code_t forced_code(input logic lvl);
    return lvl ? CODE_FULL : CODE_ZERO;
  endfunction
endpackage

// File: rtl/pwmx_sync.sv
module pwmx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic lvl_prev,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~lvl_prev;
  assign fall = ~lvl & lvl_prev;
endmodule

// File: rtl/pwmx_meter.sv
module pwmx_meter #(
  parameter int CNT_W   = 22,
  parameter int TIMEOUT = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  output logic             meas_go,
  output logic [CNT_W-1:0] hi_len,
  output logic [CNT_W-1:0] per_len,
  output logic             stuck
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] per_cnt, hi_cnt, idle_cnt;
  logic             armed;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  assign stuck   = en && (idle_cnt >= TO_LIM);
  assign meas_go = rise && armed && !stuck;
  assign hi_len  = hi_cnt;
  assign per_len = per_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      per_cnt  <= '0;
      hi_cnt   <= '0;
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else begin
      idle_cnt <= (rise || fall) ? '0 : sat_inc(idle_cnt);
      if (rise) begin
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(1);
      end else begin
        per_cnt <= sat_inc(per_cnt);
        if (lvl) hi_cnt <= sat_inc(hi_cnt);
      end
      if (rise)       armed <= 1'b1;
      else if (stuck) armed <= 1'b0;
    end
  end

  // R2: a closed period always has at least one low cycle
  p_high_below_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_go |-> (hi_cnt < per_cnt));
  // R5: any edge restarts the idle window
  p_edge_clears_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !stuck);
  // R6: an idle span disarms measurement until the next rising edge
  p_idle_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck && !rise) |=> !meas_go);
endmodule

// File: rtl/pwmx_divider.sv
module pwmx_divider
  import pwmx_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [CNT_W-1:0] num,
  input  logic [CNT_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [QBITS-1:0] quot
);
  localparam int SW = $clog2(QBITS + 1);

  logic [CNT_W:0]   rem;
  logic [CNT_W-1:0] den_q;
  logic [QBITS-1:0] q;
  logic [SW-1:0]    left;
  logic             lead;
  logic [CNT_W+1:0] step_res;

  // one restoring step: compare, conditionally subtract, emit a quotient bit
  function automatic logic [CNT_W+1:0] div_step(input logic [CNT_W:0] r,
                                                 input logic [CNT_W-1:0] d,
                                                 input logic first_bit);
    logic [CNT_W:0] trial;
    logic           ge;
    trial = first_bit ? r : {r[CNT_W-1:0], 1'b0};
    ge    = (trial >= {1'b0, d});
    return {ge, ge ? (trial - {1'b0, d}) : trial};
  endfunction

  always_comb step_res = div_step(rem, den_q, lead);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      rem   <= '0;
      den_q <= '0;
      q     <= '0;
      left  <= '0;
      lead  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem   <= {1'b0, num};
        den_q <= den;
        q     <= '0;
        left  <= SW'(QBITS);
        lead  <= 1'b1;
        busy  <= 1'b1;
      end else if (busy) begin
        rem  <= step_res[CNT_W:0];
        q    <= {q[QBITS-2:0], step_res[CNT_W+1]};
        lead <= 1'b0;
        left <= left - SW'(1);
        if (left == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q;

  // R2: the high count never exceeds the period, so the quotient stays below 256
  p_quot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quot < 9'd256));
  // R3: completion is a single-cycle event
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pwmx_filter.sv
module pwmx_filter
  import pwmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             done,
  input  logic [QBITS-1:0] quot,
  input  logic             stuck,
  input  logic             lvl_hold,
  output code_t            code,
  output logic             valid
);
  logic  pend;
  code_t raw;
  logic  adopt, pend_next;

  // adopt only on the second consecutive disagreement with the held code
  function automatic logic [1:0] hyst_decide(input code_t r, input code_t held,
                                             input logic pend_in);
    logic diff;
    diff = (r != held);
    return {diff && pend_in, diff && !pend_in};
  endfunction

  assign raw = sat_code(quot);
  assign {adopt, pend_next} = hyst_decide(raw, code, pend);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      code  <= CODE_FULL;
      pend  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (stuck) begin
        code <= forced_code(lvl_hold);
        pend <= 1'b0;
      end else if (done) begin
        valid <= 1'b1;
        pend  <= pend_next;
        if (adopt) code <= raw;
      end
    end
  end

  // R4: code only moves on a measurement, an idle timeout or disable
  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !done && !stuck) |=> $stable(code));
  // R4: a first disagreement never changes the code
  p_first_diff_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && !stuck && !pend) |=> $stable(code));
  // R5: idle timeout forces the code from the level that persisted
  p_idle_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stuck) |=> (code == forced_code($past(lvl_hold))));
  // R9: disable returns full scale and silences the strobe
  p_disable_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (code == CODE_FULL && !valid));
endmodule

// File: rtl/pwm_duty_extract.sv
module pwm_duty_extract
  import pwmx_pkg::*;
#(
  parameter int CNT_W       = 22,
  parameter int TIMEOUT     = 1_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       en,
  output logic [7:0] duty_code,
  output logic       duty_valid,
  output logic       no_edge
);
  logic             lvl, lvl_prev, rise, fall;
  logic             meas_go, stuck, div_busy, div_done;
  logic [CNT_W-1:0] hi_len, per_len;
  logic [QBITS-1:0] quot;
  code_t            code;

  pwmx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pwm_in),
    .lvl(lvl), .lvl_prev(lvl_prev), .rise(rise), .fall(fall)
  );

  pwmx_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst_n(rst_n), .en(en), .lvl(lvl), .rise(rise), .fall(fall),
    .meas_go(meas_go), .hi_len(hi_len), .per_len(per_len), .stuck(stuck)
  );

  pwmx_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .start(meas_go),
    .num(hi_len), .den(per_len),
    .busy(div_busy), .done(div_done), .quot(quot)
  );

  pwmx_filter u_filt (
    .clk(clk), .rst_n(rst_n), .en(en), .done(div_done), .quot(quot),
    .stuck(stuck), .lvl_hold(lvl_prev), .code(code), .valid(duty_valid)
  );

  assign duty_code = code;
  assign no_edge   = stuck;

  // R3: a strobe is never raised while an idle timeout is being reported
  p_valid_not_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    duty_valid |-> !$past(stuck));
  // R6: a measurement starts only when the divider is free
  p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_go && !div_busy) |=> div_busy);
endmodule

// File: tb/pwm_duty_extract_bench.sv
`timescale 1ns/1ps
module pwm_duty_extract_bench;
  localparam int CW = 12;
  localparam int TO = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       en = 1'b1;
  logic [7:0] duty_code;
  logic       duty_valid;
  logic       no_edge;

  int total = 0, bad = 0;
  int vcnt = 0, necnt = 0, chg = 0;
  logic [7:0] last_code = 8'hFF;

  always #2.5 clk = ~clk;

  pwm_duty_extract #(.CNT_W(CW), .TIMEOUT(TO), .SYNC_STAGES(2)) u_pwm_duty_extract (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .en(en),
    .duty_code(duty_code), .duty_valid(duty_valid), .no_edge(no_edge)
  );

  always @(negedge clk) begin
    if (duty_valid) vcnt++;
    if (no_edge) necnt++;
    if (duty_code != last_code) begin
      chg++;
      last_code = duty_code;
    end
  end

  function automatic int exp_code(int h, int p);
    int v;
    v = (h * 256) / p;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    en = 1'b1;
    pwm_in = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic per(int h, int l);
    pwm_in = 1'b1;
    repeat (h) @(negedge clk);
    pwm_in = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic close_period();
    pwm_in = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1 code after reset", duty_code, 255);
    check_eq("R1 valid after reset", duty_valid, 0);
    check_eq("R1 no_edge after reset", no_edge, 0);
  endtask

  task automatic t_ratio();
    int b;
    do_reset();
    b = vcnt;
    for (int i = 0; i < 3; i++) per(64, 192);
    close_period();
    check_eq("R2 code 64/256", duty_code, exp_code(64, 256));
    check_eq("R3 one strobe per period", vcnt - b, 3);
    do_reset();
    for (int i = 0; i < 2; i++) per(50, 250);
    close_period();
    check_eq("R2 code 50/300", duty_code, exp_code(50, 300));
    do_reset();
    for (int i = 0; i < 2; i++) per(100, 156);
    close_period();
    check_eq("R2 code 100/256", duty_code, exp_code(100, 256));
  endtask

  task automatic t_hyst();
    int c0;
    do_reset();
    per(64, 192); per(64, 192); per(80, 176); per(64, 192);
    close_period();
    check_eq("R4 single deviation ignored", duty_code, 64);
    do_reset();
    c0 = chg;
    for (int i = 0; i < 3; i++) begin
      per(151, 149);
      per(149, 151);
    end
    close_period();
    check_eq("R4 jitter settles", duty_code, exp_code(149, 300));
    check_eq("R4 jitter no toggling", chg - c0, 1);
    do_reset();
    per(64, 192); per(64, 192); per(80, 176); per(80, 176);
    close_period();
    check_eq("R4 two deviations adopted", duty_code, exp_code(80, 256));
  endtask

  task automatic t_idle();
    int b;
    do_reset();
    per(64, 192); per(64, 192);
    pwm_in = 1'b1;
    repeat (500) @(negedge clk);
    check_eq("R5 stuck high flag", no_edge, 1);
    check_eq("R5 stuck high code", duty_code, 255);
    pwm_in = 1'b0;
    repeat (500) @(negedge clk);
    check_eq("R5 stuck low flag", no_edge, 1);
    check_eq("R5 stuck low code", duty_code, 0);
    b = vcnt;
    per(100, 156);
    check_eq("R5 flag cleared by edge", no_edge, 0);
    check_eq("R6 first edge only arms", vcnt - b, 0);
    per(100, 156);
    close_period();
    check_eq("R6 code after rearm", duty_code, exp_code(100, 256));
    check_eq("R6 strobes after rearm", vcnt - b, 2);
  endtask

  task automatic t_coincide();
    int b, n;
    do_reset();
    b = vcnt; n = necnt;
    per(64, 192); per(64, 192); per(64, TO + 1);
    per(64, 192); per(64, 192);
    check_eq("R8 flag one cycle", necnt - n, 1);
    check_eq("R8 forced low code", duty_code, 0);
    check_eq("R8 strobes", vcnt - b, 3);
    close_period();
    check_eq("R8 recovered code", duty_code, 64);
    do_reset();
    b = vcnt; n = necnt;
    per(64, 192); per(64, 192); per(64, TO);
    close_period();
    check_eq("R8 control no flag", necnt - n, 0);
    check_eq("R8 control strobes", vcnt - b, 3);
    check_eq("R8 control code held", duty_code, 64);
  endtask

  task automatic t_extremes();
    do_reset();
    for (int i = 0; i < 2; i++) per(1, 399);
    close_period();
    check_eq("R7 minimum duty", duty_code, exp_code(1, 400));
    do_reset();
    per(200, 200); per(200, 200); per(399, 1); per(399, 1);
    close_period();
    check_eq("R7 maximum duty", duty_code, exp_code(399, 400));
  endtask

  task automatic t_enable();
    do_reset();
    for (int i = 0; i < 3; i++) per(64, 192);
    check_eq("R9 precondition", duty_code, 64);
    en = 1'b0;
    @(negedge clk);
    check_eq("R9 code full when disabled", duty_code, 255);
    check_eq("R9 no strobe when disabled", duty_valid, 0);
    pwm_in = 1'b1;
    repeat (500) @(negedge clk);
    check_eq("R9 no idle flag when disabled", no_edge, 0);
    en = 1'b1;
    pwm_in = 1'b0;
    repeat (4) @(negedge clk);
    per(64, 192); per(64, 192);
    close_period();
    check_eq("R9 resumes after enable", duty_code, 64);
  endtask

  initial begin
    t_reset();
    t_ratio();
    t_hyst();
    t_idle();
    t_coincide();
    t_extremes();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1-run actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule